// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a memory-mapped SPI master. Software sets it up through a small bank of word registers: frame shape and clock mode, burst length, clock divider and a one-hot slave-select mask. It then fills a transmit FIFO and sets a run bit. The block shifts a programmed number of 8-bit or 16-bit frames, most significant bit first, in any of the four clock-polarity and clock-phase combinations. It works full duplex, so every frame sent also captures one frame into a receive FIFO. Software polls a status register to find out when it can push transmit words, pop receive words and treat the burst as complete.

Frame shape, burst length and divider can only be changed while the run bit is clear. Chip-select lines come straight from the select mask and stay asserted across every frame of a burst. When the transmit FIFO runs dry in the middle of a burst, the serial clock parks at its idle level and waits for data. Clearing the run bit ends the burst at once and empties both FIFOs.

Top module: `spim_top`

## Requirements
- R1: After reset, STATUS reads 4 (not busy, TX FIFO not full, RX FIFO empty), every `cs_n` line is high and `sclk` is low.
- R2: The word addresses are: CFG=0 (bit0 16-bit frames, bit1 CPOL, bit2 CPHA), COUNT=1 (frames minus one, 16 bits), RUN=2 (bit0), SELECT=3, DIVIDER=4, STATUS=5 (bit0 busy, bit1 TX full, bit2 RX empty), TXDATA=6 (write pushes), RXDATA=7 (read pops). CFG, COUNT, RUN, SELECT and DIVIDER read back what was stored.
- R3: Writes to CFG, COUNT and DIVIDER have no effect while RUN bit0 is 1.
- R4: `cs_n[n]` is low exactly when SELECT bit n is 1. Writing 0 to SELECT raises every line.
- R5: Writing RUN=1 while RUN is 0 starts a burst of COUNT+1 frames. Busy is 1 from the next cycle until the last frame's receive word enters the RX FIFO.
- R6: Each frame puts 8 or 16 bits on `mosi`, MSB first, and captures the same number of `miso` bits. In 8-bit mode the captured word is zero-extended.
- R7: `sclk` idles at CPOL. With CPHA=0, data is sampled on the leading edge of each clock pulse; with CPHA=1, on the trailing edge.
- R8: Each `sclk` half period lasts E/2 cycles, where E is DIVIDER with bit0 cleared and raised to 2 if smaller.
- R9: The first `sclk` edge of a burst comes no earlier than E cycles after the RUN write.
- R10: When the TX FIFO is empty between frames of a burst, `sclk` stays at CPOL and busy stays 1. The burst resumes once a word is pushed.
- R11: Each FIFO holds 32 entries. A TXDATA write while the TX FIFO is full is dropped. An RXDATA read while the RX FIFO is empty returns 0 and removes nothing.
- R12: Writing RUN=0 ends any burst, empties both FIFOs and returns `sclk` to CPOL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RXDATA) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
A wrong bit counter or edge-phase choice in the shift engine shows up within one frame: the captured `mosi` word or the looped-back receive word differs, or the `sclk` edge count of the burst comes out wrong. A wrong frame counter or FIFO pointer shows up when the burst ends, as busy falling early or late, a lost or repeated receive word, or a wrong empty/full flag. The bench sweeps every clock mode, both frame sizes and odd, even and undersized dividers. It also exercises a mid-burst stall, an abort, a dropped push into a full FIFO and locked configuration writes.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Widths of the divider and of the widest frame.
    localparam int DIV_W   = 16;
    localparam int FRAME_W = 16;

    typedef enum logic [2:0] {
        A_CFG    = 3'd0,
        A_COUNT  = 3'd1,
        A_RUN    = 3'd2,
        A_SELECT = 3'd3,
        A_DIV    = 3'd4,
        A_STATUS = 3'd5,
        A_TXDATA = 3'd6,
        A_RXDATA = 3'd7
    } reg_addr_e;

    // bit0 wide, bit1 cpol, bit2 cpha
    typedef struct packed {
        logic cpha;
        logic cpol;
        logic wide;
    } frame_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_WAIT,
        ST_SHIFT
    } eng_state_e;

    // Half period in input cycles: divider forced even and at least 2.
    function automatic logic [DIV_W-1:0] half_period(input logic [DIV_W-1:0] div);
        return (div < DIV_W'(4)) ? DIV_W'(1) : {1'b0, div[DIV_W-1:1]};
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    // DEPTH must be a power of two; pointers carry one wrap bit.
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp, rp;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= wdata;
    end

    assign rdata = mem[rp[AW-1:0]];
    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               abort,
    input  frame_cfg_t         cfg,
    input  logic [DIV_W-1:0]   half,
    input  logic [CNT_W:0]     frames,
    input  logic               tx_empty,
    input  logic [FRAME_W-1:0] tx_data,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_data,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               busy
);
    localparam int TW = DIV_W + 1;
    localparam logic [TW-1:0]    T_ONE = TW'(1);
    localparam logic [CNT_W:0]   F_ONE = (CNT_W+1)'(1);

    eng_state_e         st;
    logic [TW-1:0]      tmr;
    logic [4:0]         edge_idx;
    logic [CNT_W:0]     left;
    logic [FRAME_W-1:0] tx_sh, rx_sh, rx_next;
    logic               sclk_q;
    logic [4:0]         last_edge;
    logic               tick, leading, do_sample, do_shift;

    assign last_edge = cfg.wide ? 5'd31 : 5'd15;
    assign tick      = (st == ST_SHIFT) && (tmr == {1'b0, half} - T_ONE);
    assign leading   = ~edge_idx[0];
    // CPHA=0 samples on leading edges, CPHA=1 on trailing ones.
    assign do_sample = tick && (leading ^ cfg.cpha);
    assign do_shift  = tick && !(leading ^ cfg.cpha)
                       && (edge_idx != 5'd0) && (edge_idx != last_edge);
    assign rx_next   = do_sample ? {rx_sh[FRAME_W-2:0], miso} : rx_sh;
    assign rx_push   = tick && (edge_idx == last_edge);
    assign rx_data   = cfg.wide ? rx_next : {8'h00, rx_next[7:0]};
    assign tx_pop    = (st == ST_WAIT) && !tx_empty && !rx_full;
    assign mosi      = cfg.wide ? tx_sh[15] : tx_sh[7];
    assign sclk      = sclk_q;
    assign busy      = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tmr      <= '0;
            edge_idx <= '0;
            left     <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            sclk_q   <= 1'b0;
        end else if (abort) begin
            st     <= ST_IDLE;
            sclk_q <= cfg.cpol;
        end else begin
            case (st)
                ST_IDLE: begin
                    sclk_q <= cfg.cpol;
                    if (start) begin
                        st   <= ST_LEAD;
                        tmr  <= '0;
                        left <= frames;
                    end
                end
                ST_LEAD: begin
                    // one full serial clock between select and first edge
                    if (tmr == {half, 1'b0} - T_ONE) begin
                        st  <= ST_WAIT;
                        tmr <= '0;
                    end else begin
                        tmr <= tmr + T_ONE;
                    end
                end
                ST_WAIT: begin
                    if (tx_pop) begin
                        tx_sh    <= tx_data;
                        rx_sh    <= '0;
                        edge_idx <= '0;
                        tmr      <= '0;
                        st       <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        tmr      <= '0;
                        sclk_q   <= ~sclk_q;
                        edge_idx <= edge_idx + 5'd1;
                        rx_sh    <= rx_next;
                        if (do_shift) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                        if (rx_push) begin
                            left <= left - F_ONE;
                            st   <= (left == F_ONE) ? ST_IDLE : ST_WAIT;
                        end
                    end else begin
                        tmr <= tmr + T_ONE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_stall_parks_clock_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (sclk_q == cfg.cpol));
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st == ST_IDLE) && $stable(cfg.cpol)) |-> (sclk_q == cfg.cpol));
    assert_push_has_room_R6: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);
    assert_busy_until_push_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !abort && !rx_push) |=> busy);

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int NCS        = 4,
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [2:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);
    frame_cfg_t         cfg_q;
    logic [CNT_W-1:0]   count_q;
    logic               en_q;
    logic [NCS-1:0]     sel_q;
    logic [DIV_W-1:0]   div_q;
    reg_addr_e          addr;
    logic               wr_run, start, abort;
    logic               tx_push, tx_pop, tx_full, tx_empty;
    logic               rx_push, rx_pop, rx_full, rx_empty;
    logic [FRAME_W-1:0] tx_rdata, rx_wdata, rx_rdata;
    logic               busy;
    logic               unused_wdata;

    assign addr         = reg_addr_e'(bus_addr);
    assign unused_wdata = ^bus_wdata[31:16];
    assign wr_run       = bus_wr && (addr == A_RUN);
    assign start        = wr_run && bus_wdata[0] && !en_q;
    assign abort        = wr_run && !bus_wdata[0];
    assign tx_push      = bus_wr && (addr == A_TXDATA) && !tx_full;
    assign rx_pop       = bus_rd && (addr == A_RXDATA) && !rx_empty;
    assign cs_n         = ~sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            count_q <= '0;
            en_q    <= 1'b0;
            sel_q   <= '0;
            div_q   <= '0;
        end else if (bus_wr) begin
            case (addr)
                A_CFG:    if (!en_q) cfg_q   <= frame_cfg_t'(bus_wdata[2:0]);
                A_COUNT:  if (!en_q) count_q <= bus_wdata[CNT_W-1:0];
                A_DIV:    if (!en_q) div_q   <= bus_wdata[DIV_W-1:0];
                A_RUN:    en_q  <= bus_wdata[0];
                A_SELECT: sel_q <= bus_wdata[NCS-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_CFG:    bus_rdata = {29'd0, cfg_q};
            A_COUNT:  bus_rdata = 32'(count_q);
            A_RUN:    bus_rdata = {31'd0, en_q};
            A_SELECT: bus_rdata = 32'(sel_q);
            A_DIV:    bus_rdata = 32'(div_q);
            A_STATUS: bus_rdata = {29'd0, rx_empty, tx_full, busy};
            A_RXDATA: bus_rdata = rx_empty ? 32'd0 : 32'(rx_rdata);
            default:  bus_rdata = 32'd0;
        endcase
    end

    spim_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(abort),
        .push(tx_push), .wdata(bus_wdata[FRAME_W-1:0]),
        .pop(tx_pop), .rdata(tx_rdata), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(abort),
        .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_rdata), .full(rx_full), .empty(rx_empty)
    );

    spim_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .cfg(cfg_q), .half(half_period(div_q)),
        .frames({1'b0, count_q} + (CNT_W+1)'(1)),
        .tx_empty(tx_empty), .tx_data(tx_rdata), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_wdata),
        .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy)
    );

    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (en_q && bus_wr && addr == A_CFG) |=> $stable(cfg_q));
    assert_count_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (en_q && bus_wr && addr == A_COUNT) |=> $stable(count_q));
    assert_select_release_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr == A_SELECT && bus_wdata[NCS-1:0] == '0) |=> (&cs_n));
    assert_abort_idles_R12: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && rx_empty && tx_empty));

endmodule

// File: tb/spim_top_test.sv
module spim_top_test;
    import spim_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;
    logic        miso_inv = 1'b0;

    always #4 clk = ~clk;
    assign miso = mosi ^ miso_inv;

    spim_top uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int checks = 0, fails = 0;
    int cyc = 0;

    // serial monitor: parameters set by the stimulus, state owned here
    logic mon_cpol = 1'b0, mon_cpha = 1'b0;
    int   mon_bits = 8, mon_gen = 0, seen_gen = 0;
    int   mon_edges, mon_min_gap, mon_last, mon_first, mon_bitcnt, mon_nw;
    logic [15:0] mon_word;
    logic [15:0] mon_words [64];
    logic prev_sclk = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (seen_gen != mon_gen) begin
            seen_gen = mon_gen; mon_edges = 0; mon_min_gap = 1000000;
            mon_first = -1; mon_bitcnt = 0; mon_nw = 0; mon_word = 16'd0;
        end
        if (sclk !== prev_sclk) begin
            mon_edges = mon_edges + 1;
            if (mon_first < 0) mon_first = cyc;
            else if (cyc - mon_last < mon_min_gap) mon_min_gap = cyc - mon_last;
            mon_last = cyc;
            if ((sclk != mon_cpol) ^ mon_cpha) begin
                mon_word = {mon_word[14:0], mosi};
                mon_bitcnt = mon_bitcnt + 1;
                if (mon_bitcnt == mon_bits) begin
                    if (mon_nw < 64) mon_words[mon_nw] = mon_word;
                    mon_nw = mon_nw + 1;
                    mon_bitcnt = 0; mon_word = 16'd0;
                end
            end
        end
        prev_sclk = sclk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input string what, input int act, input int lim);
        checks++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected at least %0d", req, what, act, lim);
        end
    endtask

    task automatic wr(input reg_addr_e a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input reg_addr_e a, output int d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle(output int st);
        st = 1;
        for (int i = 0; i < 4000 && st[0]; i++) rd(A_STATUS, st);
    endtask

    function automatic logic [15:0] pattern(input int seed, input int k);
        return 16'((seed * 40503 + k * 9973 + 17) ^ (k << 13));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int v, st, t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_STATUS, v);   chk("R1", "status after reset", v, 4);
        chk("R1", "cs_n after reset", int'(cs_n), 15);
        chk("R1", "sclk after reset", int'(sclk), 0);

        // R4 chip select lines, R2 readback
        wr(A_SELECT, 4'b1010);
        chk("R4", "cs_n with mask 1010", int'(cs_n), 4'b0101);
        rd(A_SELECT, v);   chk("R2", "SELECT readback", v, 4'b1010);
        wr(A_SELECT, 0);
        chk("R4", "cs_n released", int'(cs_n), 15);

        // R6 R7 R8 R9 R5: sweep of modes, sizes and dividers
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int di = 0; di < 3; di++) begin
                    int dv, h, nb, seed, cfgv;
                    logic [15:0] txw [3];
                    logic [15:0] mask, expw;
                    dv   = (di == 0) ? 0 : (di == 1) ? 5 : 6;
                    h    = (dv < 4) ? 1 : dv / 2;
                    nb   = w ? 16 : 8;
                    seed = m * 6 + w * 3 + di;
                    mask = w ? 16'hFFFF : 16'h00FF;
                    cfgv = w | ((m >> 1) << 1) | ((m & 1) << 2);
                    wr(A_RUN, 0);
                    wr(A_CFG, cfgv);
                    wr(A_COUNT, 2);
                    wr(A_DIV, dv);
                    wr(A_SELECT, 1);
                    rd(A_CFG, v);  chk("R2", "CFG readback", v, cfgv);
                    rd(A_DIV, v);  chk("R2", "DIVIDER readback", v, dv);
                    for (int k = 0; k < 3; k++) begin
                        txw[k] = pattern(seed, k);
                        wr(A_TXDATA, int'(txw[k]));
                    end
                    mon_cpol = m[1]; mon_cpha = m[0]; mon_bits = nb;
                    miso_inv = seed[0];
                    mon_gen++;
                    wr(A_RUN, 1);
                    t0 = cyc;
                    rd(A_STATUS, v); chk("R5", "busy after start", v & 1, 1);
                    chk("R4", "cs_n during burst", int'(cs_n), 4'b1110);
                    wait_idle(st);
                    chk("R5", "busy cleared after burst", st & 1, 0);
                    chk("R5", "edge count of 3 frames", mon_edges, 6 * nb);
                    chk("R8", "half period", mon_min_gap, h);
                    chk_ge("R9", "lead to first edge", mon_first - t0, 2 * h);
                    chk("R7", "sclk idle level after burst", int'(sclk), m >> 1);
                    for (int k = 0; k < 3; k++) begin
                        expw = (txw[k] ^ (miso_inv ? 16'hFFFF : 16'h0000)) & mask;
                        rd(A_RXDATA, v);
                        chk("R6", "received word", v, int'(expw));
                        chk("R7", "mosi word at sample edges", int'(mon_words[k]), int'(txw[k] & mask));
                    end
                    if (seed == 5) begin
                        // R3 locked configuration while RUN=1
                        wr(A_CFG, 7); wr(A_COUNT, 9); wr(A_DIV, 40);
                        rd(A_CFG, v);   chk("R3", "CFG locked", v, cfgv);
                        rd(A_COUNT, v); chk("R3", "COUNT locked", v, 2);
                        rd(A_DIV, v);   chk("R3", "DIVIDER locked", v, dv);
                        rd(A_RUN, v);   chk("R2", "RUN readback", v, 1);
                    end
                end
            end
        end

        // R10 stall on empty TX FIFO
        miso_inv = 1'b0;
        wr(A_RUN, 0); wr(A_CFG, 0); wr(A_COUNT, 2); wr(A_DIV, 2);
        mon_cpol = 1'b0; mon_cpha = 1'b0; mon_bits = 8; mon_gen++;
        wr(A_TXDATA, 8'hA5);
        wr(A_RUN, 1);
        repeat (200) @(negedge clk);
        rd(A_STATUS, v);
        chk("R10", "busy during stall", v & 1, 1);
        chk("R10", "edges before stall", mon_edges, 16);
        chk("R10", "sclk parked", int'(sclk), 0);
        wr(A_TXDATA, 8'h3C); wr(A_TXDATA, 8'h81);
        wait_idle(st);
        chk("R10", "edges after resume", mon_edges, 48);
        rd(A_RXDATA, v); chk("R10", "rx word 0", v, 8'hA5);
        rd(A_RXDATA, v); chk("R10", "rx word 1", v, 8'h3C);
        rd(A_RXDATA, v); chk("R10", "rx word 2", v, 8'h81);

        // R12 abort mid burst
        wr(A_RUN, 0); wr(A_CFG, 2); wr(A_COUNT, 9); wr(A_DIV, 8);
        mon_cpol = 1'b1; mon_cpha = 1'b0; mon_gen++;
        for (int k = 0; k < 10; k++) wr(A_TXDATA, k + 1);
        wr(A_RUN, 1);
        repeat (60) @(negedge clk);
        wr(A_RUN, 0);
        rd(A_STATUS, v); chk("R12", "status after abort", v, 4);
        chk("R12", "sclk at CPOL after abort", int'(sclk), 1);
        v = mon_edges;
        repeat (50) @(negedge clk);
        chk("R12", "no edges after abort", mon_edges, v);
        rd(A_RXDATA, st); chk("R12", "RX flushed", st, 0);

        // R11 FIFO depth, dropped push, empty read
        wr(A_RUN, 0); wr(A_CFG, 0); wr(A_COUNT, 31); wr(A_DIV, 0);
        rd(A_COUNT, v); chk("R2", "COUNT readback", v, 31);
        mon_cpol = 1'b0; mon_cpha = 1'b0; mon_gen++;
        for (int k = 0; k < 33; k++) wr(A_TXDATA, (k * 7 + 3) & 255);
        rd(A_STATUS, v); chk("R11", "TX full with 32 words", v, 6);
        rd(A_RXDATA, v); chk("R11", "empty RX read returns 0", v, 0);
        wr(A_RUN, 1);
        wait_idle(st);
        chk("R11", "edges of 32 frames", mon_edges, 512);
        for (int k = 0; k < 32; k++) begin
            rd(A_RXDATA, v);
            chk("R11", "rx word of full burst", v, (k * 7 + 3) & 255);
        end
        rd(A_STATUS, v); chk("R11", "status after draining", v, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule